// File: doc/BRIEF.md
# Time-Compared Pulse-Per-Second Generator

This block produces a once-per-period timing pulse by watching the whole-nanosecond field of a time-of-day counter and comparing it with a 64-bit threshold. The threshold is held in fixed point: whole nanoseconds in the upper 32 bits and a binary fraction in the lower 32 bits. Each time the running time reaches the threshold, the output changes level. The threshold then moves forward by one of two increments, chosen by the new level. One increment sets how long the output stays high and the other how long it stays low.

The sum is taken modulo a seconds-rollover value (a parameter, one billion by default). When the advance wraps past that value, comparisons stop until the time input has also wrapped. This prevents an early edge in the last part of the second. Surrounding logic supplies the enable, the polarity invert, the two increments and a direct threshold load. Software can use that load to realign the edge within the second, for example by writing 500,000,000 ns. The counter that produces the time value lies outside this block.

Top module: `pps_edge_gen`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `pps_out` is 0, the internal phase is low and the threshold is 0.
- R2: While `cfg_en` is 0, no edge fires and the phase returns to low. On the cycle after, `pps_out` equals that cycle's `cfg_inv`.
- R3: With `cfg_en` 1, no load pending and no hold active, a cycle in which `now_ns` is at or above threshold bits 63:32 toggles the phase. The new level shows on `pps_out` after that clock edge.
- R4: When the phase turns high, the full 64-bit `hi_incr` is added to the threshold. When it turns low, `lo_incr` is added. Whole nanoseconds sit in bits 63:32.
- R5: If the advanced threshold is at or above `ROLL_NS` shifted into bits 63:32, that value is subtracted. Increments are expected to be below the rollover.
- R6: After a wrapping advance, no edge fires until a cycle in which `now_ns` is lower than on the cycle before. That cycle is itself eligible to fire.
- R7: A `thr_wr` pulse loads `thr_wdata` as the threshold on the next cycle and clears any hold. No edge fires in the load cycle.
- R8: `pps_out` equals the phase XOR `cfg_inv`, with `cfg_inv` taken in the same cycle as the phase update.
- R9: With both increments equal to 500,000,000 ns (0x1DCD6500 in bits 63:32), the output is a square wave of one rollover period with 50% duty. A low increment one sample step short still yields edges at the one-second boundary.
- R10: The fraction bits 31:0 of threshold and increments accumulate, and a carry out of them moves the whole-nanosecond compare point.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Generator enable |
| cfg_inv | input | 1 | Output polarity invert |
| thr_wr | input | 1 | Threshold load strobe |
| thr_wdata | input | 64 | Threshold load value (ns in 63:32, fraction in 31:0) |
| hi_incr | input | 64 | Increment applied when the phase turns high |
| lo_incr | input | 64 | Increment applied when the phase turns low |
| now_ns | input | 32 | Whole-nanosecond field of the time-of-day counter |
| pps_out | output | 1 | Registered pulse output |

## Verification
The main function is driven with a time input stepping evenly by 10 ms. At that step every threshold is hit exactly, which tells a correct at-or-beyond compare from an off-by-one compare. The period and the duty cycle are also measured in cycles. A short low increment shows that the boundary edge survives when the time wraps. Irregular step sizes and increments with fraction bits separate correct fixed-point accumulation from accumulation of whole nanoseconds only. Threshold loads issued while a wrap hold is pending, polarity flips and disabling mid-phase show the hold clear, the load-cycle edge suppression and the return to the inactive level.

// File: rtl/pps_pkg.sv
package pps_pkg;
    localparam int NS_W   = 32;
    localparam int FRAC_W = 32;
    localparam int TFX_W  = NS_W + FRAC_W;

    typedef struct packed {
        logic [TFX_W-1:0] thr;
        logic             level;
        logic             hold;
        logic             out;
        logic [NS_W-1:0]  prev_ns;
    } pps_state_t;
endpackage

// File: rtl/pps_thr_adv.sv
module pps_thr_adv
    import pps_pkg::*;
#(
    parameter logic [NS_W-1:0] ROLL_NS = 32'd1_000_000_000
) (
    input  logic [TFX_W-1:0] thr_cur,
    input  logic [TFX_W-1:0] incr,
    output logic [TFX_W-1:0] thr_nxt,
    output logic             wrapped
);
    localparam logic [TFX_W:0] ROLL_FX = {1'b0, ROLL_NS, {FRAC_W{1'b0}}};

    logic [TFX_W:0] sum_raw;
    logic [TFX_W:0] sum_sub;

    always_comb begin
        sum_raw = {1'b0, thr_cur} + {1'b0, incr};
        sum_sub = sum_raw - ROLL_FX;
        wrapped = (sum_raw >= ROLL_FX);
        thr_nxt = wrapped ? sum_sub[TFX_W-1:0] : sum_raw[TFX_W-1:0];
    end
endmodule

// File: rtl/pps_fire_ctl.sv
module pps_fire_ctl
    import pps_pkg::*;
(
    input  logic            en,
    input  logic            hold,
    input  logic [NS_W-1:0] now_ns,
    input  logic [NS_W-1:0] prev_ns,
    input  logic [NS_W-1:0] thr_whole,
    output logic            time_wrapped,
    output logic            fire
);
    logic eligible;

    always_comb begin
        time_wrapped = (now_ns < prev_ns);
        eligible     = !hold || time_wrapped;
        fire         = en && eligible && (now_ns >= thr_whole);
    end
endmodule

// File: rtl/pps_edge_gen.sv
module pps_edge_gen
    import pps_pkg::*;
#(
    parameter logic [NS_W-1:0] ROLL_NS = 32'd1_000_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_inv,
    input  logic             thr_wr,
    input  logic [TFX_W-1:0] thr_wdata,
    input  logic [TFX_W-1:0] hi_incr,
    input  logic [TFX_W-1:0] lo_incr,
    input  logic [NS_W-1:0]  now_ns,
    output logic             pps_out
);
    pps_state_t st_q, st_d;

    logic             fire;
    logic             time_wrapped;
    logic             adv_wrapped;
    logic [TFX_W-1:0] step_incr;
    logic [TFX_W-1:0] adv_thr;

    // the level after a toggle is the inverse of the current one
    assign step_incr = st_q.level ? lo_incr : hi_incr;

    pps_thr_adv #(.ROLL_NS(ROLL_NS)) adv_i (
        .thr_cur (st_q.thr),
        .incr    (step_incr),
        .thr_nxt (adv_thr),
        .wrapped (adv_wrapped)
    );

    pps_fire_ctl fire_i (
        .en           (cfg_en),
        .hold         (st_q.hold),
        .now_ns       (now_ns),
        .prev_ns      (st_q.prev_ns),
        .thr_whole    (st_q.thr[TFX_W-1:FRAC_W]),
        .time_wrapped (time_wrapped),
        .fire         (fire)
    );

    always_comb begin
        st_d         = st_q;
        st_d.prev_ns = now_ns;
        if (thr_wr) begin
            st_d.thr  = thr_wdata;
            st_d.hold = 1'b0;
        end else if (fire) begin
            st_d.level = !st_q.level;
            st_d.thr   = adv_thr;
            st_d.hold  = adv_wrapped;
        end else if (st_q.hold && time_wrapped) begin
            st_d.hold = 1'b0;
        end
        if (!cfg_en) begin
            st_d.level = 1'b0;
        end
        st_d.out = st_d.level ^ cfg_inv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pps_out = st_q.out;

    AST_DIS_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> (pps_out == $past(cfg_inv)));                          // R2
    AST_TOGGLE_NEEDS_REACH: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.level != $past(st_q.level)) && $past(cfg_en))
        |-> ($past(now_ns) >= $past(st_q.thr[TFX_W-1:FRAC_W])));           // R3
    AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.hold && cfg_en && (now_ns >= st_q.prev_ns)) |=> $stable(st_q.level)); // R6
    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        thr_wr |=> (st_q.thr == $past(thr_wdata) && !st_q.hold));           // R7
    AST_WRITE_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_wr && cfg_en) |=> $stable(st_q.level));                        // R7
endmodule

// File: tb/pps_edge_gen_tb_top.sv
module pps_edge_gen_tb_top;
    localparam longint unsigned ROLL    = 64'd1_000_000_000;
    localparam longint unsigned ROLL_FX = ROLL << 32;
    localparam longint unsigned HALF    = 64'd500_000_000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en = 1'b0;
    logic        cfg_inv = 1'b0;
    logic        thr_wr = 1'b0;
    logic [63:0] thr_wdata = '0;
    logic [63:0] hi_incr = '0;
    logic [63:0] lo_incr = '0;
    logic [31:0] now_ns = '0;
    logic        pps_out;

    always #10 clk = ~clk;

    pps_edge_gen dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_inv(cfg_inv),
        .thr_wr(thr_wr), .thr_wdata(thr_wdata), .hi_incr(hi_incr),
        .lo_incr(lo_incr), .now_ns(now_ns), .pps_out(pps_out)
    );

    int unsigned     n_cmp = 0;
    int unsigned     n_bad = 0;
    string           req = "R1";
    longint unsigned m_thr = 0;
    bit              m_lvl = 0;
    bit              m_hold = 0;
    bit              m_out = 0;
    longint unsigned m_prev = 0;
    longint unsigned tns = 0;
    int unsigned     cyc = 0;
    bit              finished = 0;

    task automatic check(input string r, input bit act, input bit exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual %0b expected %0b", r, cyc, act, exp);
        end
    endtask

    task automatic check_int(input string r, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", r, cyc, act, exp);
        end
    endtask

    // behavioural reference: one clock of the generator
    task automatic tick();
        longint unsigned now = longint'(now_ns);
        longint unsigned sum;
        bit fire;
        bit time_back = (now < m_prev);
        fire = cfg_en && !thr_wr && (!m_hold || time_back) && (now >= (m_thr >> 32));
        if (thr_wr) begin
            m_thr  = thr_wdata;
            m_hold = 0;
        end else if (fire) begin
            m_lvl = !m_lvl;
            sum   = m_thr + (m_lvl ? hi_incr : lo_incr);
            if (sum >= ROLL_FX) begin
                sum    = sum - ROLL_FX;
                m_hold = 1;
            end else begin
                m_hold = 0;
            end
            m_thr = sum;
        end else if (m_hold && time_back) begin
            m_hold = 0;
        end
        if (!cfg_en) m_lvl = 0;
        m_out  = m_lvl ^ cfg_inv;
        m_prev = now;
        @(posedge clk);
        @(negedge clk);
        cyc++;
        check(req, pps_out, m_out);
    endtask

    task automatic advance_time(input longint unsigned step);
        tns = tns + step;
        if (tns >= ROLL) tns = tns - ROLL;
        now_ns = tns[31:0];
    endtask

    task automatic run(input int n, input longint unsigned step);
        for (int i = 0; i < n; i++) begin
            tick();
            advance_time(step);
        end
    endtask

    task automatic load_thr(input longint unsigned v, input longint unsigned step);
        thr_wr    = 1'b1;
        thr_wdata = v;
        tick();
        thr_wr = 1'b0;
        advance_time(step);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int last_rise;
        int last_fall;
        int rise_gap;
        int high_len;
        bit prev_out;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", pps_out, 1'b0);
        rst_n = 1'b1;
        req = "R1";
        run(2, 10_000_000);

        // R2: disabled, time sweeping past the zero threshold
        req = "R2";
        run(20, 10_000_000);
        // R8: invert while disabled gives the inactive level 1
        req = "R8";
        cfg_inv = 1'b1;
        run(5, 10_000_000);
        cfg_inv = 1'b0;

        // R9, R3, R4, R5, R6: 1 s square wave, even 10 ms steps from zero
        req = "R9";
        tns = 0; now_ns = 0;
        hi_incr = HALF << 32;
        lo_incr = HALF << 32;
        cfg_en  = 1'b1;
        load_thr(HALF << 32, 0);
        last_rise = -1; last_fall = -1; rise_gap = 0; high_len = 0;
        prev_out = pps_out;
        for (int i = 0; i < 400; i++) begin
            req = (i % 2 == 0) ? "R3" : "R6";
            tick();
            advance_time(10_000_000);
            if (pps_out && !prev_out) begin
                if (last_rise >= 0) rise_gap = i - last_rise;
                last_rise = i;
            end
            if (!pps_out && prev_out && last_rise >= 0) high_len = i - last_rise;
            if (!pps_out && prev_out) last_fall = i;
            prev_out = pps_out;
        end
        check_int("R9 period", rise_gap, 100);
        check_int("R9 duty", high_len, 50);
        check("R9 fall seen", last_fall >= 0, 1'b1);

        // R8: invert while running
        req = "R8";
        cfg_inv = 1'b1;
        run(120, 10_000_000);
        cfg_inv = 1'b0;

        // R9: low phase one step short still meets the boundary
        req = "R9";
        lo_incr = (HALF - 20_000_000) << 32;
        run(400, 20_000_000);

        // R10 / R4: fractional increments with irregular steps
        req = "R10";
        hi_incr = (64'd123_456_789 << 32) | 64'h8000_0000;
        lo_incr = (64'd300_000_000 << 32) | 64'h4000_0001;
        run(600, 3_000_017);
        req = "R4";
        run(300, 7_654_321);

        // R5: increments that force frequent wraps
        req = "R5";
        hi_incr = 64'd900_000_000 << 32;
        lo_incr = 64'd950_000_000 << 32;
        run(400, 13_000_000);

        // R7: load while a wrap hold is pending; load-cycle edge suppressed
        req = "R7";
        for (int k = 0; k < 6; k++) begin
            run(37, 13_000_000);
            load_thr(64'd100 << 32, 13_000_000);
            run(3, 13_000_000);
        end
        load_thr(64'd999_999_999 << 32, 5_000_000);
        run(250, 5_000_000);

        // R2: disable in the middle of a high phase, then re-enable
        req = "R2";
        hi_incr = HALF << 32;
        lo_incr = HALF << 32;
        run(80, 10_000_000);
        cfg_en = 1'b0;
        run(30, 10_000_000);
        cfg_inv = 1'b1;
        run(10, 10_000_000);
        cfg_inv = 1'b0;
        cfg_en  = 1'b1;
        run(250, 10_000_000);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule